// File: doc/BRIEF.md
# Cache Port Turnaround Spacing Enforcer

This block stands between the request logic and an external cache's data/tag pins. It decides, in every core clock cycle, whether a pending read or a pending write may go out. Two requests in the same direction may follow each other with no gap. A change of direction must wait until a minimum number of core cycles has passed since the last transfer in the other direction. These gaps protect the shared data/tag pins from bus contention.

The two gaps are set by configuration inputs. The read-then-write gap is a programmed bubble count plus a fixed six cycles, and a count of zero stands for sixty-four. The write-then-read gap is the programmed bubble count minus one, multiplied by the frame-clock period given in core cycles. A special single-data mode subtracts two from the bubble count instead of one.

When a transfer is granted, the block loads a countdown with that transfer's limit, taken from the configuration present in that cycle. A request in the opposite direction is held until the countdown reaches zero. Grants are combinational from the request inputs and the registered spacing state.

Top module: `turnaround_gap_ctrl`

## Requirements
- R1: After reset no spacing is pending. With no request, neither grant is asserted. The first request after reset is granted in the cycle it is presented.
- R2: A request in the same direction as the last granted transfer is granted in the cycle it is presented, even while spacing is pending. Each grant restarts the spacing from that cycle.
- R3: With `single_rate_mode`=0 and `wr_bubbles`=B≥2, a read after a write granted in cycle t is not granted before cycle t+(B−1)×`frame_period`. If the read is held, it is granted in exactly that cycle.
- R4: A write after a read granted in cycle t is not granted before cycle t+N+6. N is the value of `rd_bubbles`, except that `rd_bubbles`=0 means N=64. If the write is held, it is granted in exactly that cycle.
- R5: With `single_rate_mode`=1 and `wr_bubbles`=B≥3, the write-then-read gap is (B−2)×`frame_period` core cycles.
- R6: A `wr_bubbles` value below 2 (normal mode) or below 3 (`single_rate_mode`=1) gives a write-then-read gap of zero, so a read may be granted in the cycle after a write.
- R7: If a read and a write are requested in the same cycle and no spacing is pending, the read is granted and the write is held.
- R8: A grant is asserted only while its own request is asserted, and the two grants are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read transfer requested this cycle |
| wr_req | input | 1 | Write transfer requested this cycle |
| rd_bubbles | input | 6 | Read-to-write bubble count (0 means 64) |
| wr_bubbles | input | 4 | Write-to-read bubble count |
| frame_period | input | 4 | Frame-clock period in core cycles (1 to 8) |
| single_rate_mode | input | 1 | Selects the minus-two write-to-read formula |
| rd_grant | output | 1 | Read may issue this cycle |
| wr_grant | output | 1 | Write may issue this cycle |

## Verification
The bench holds an opposite-direction request steady after a grant. This shows whether the first grant lands on the exact cycle the formula predicts, rather than one cycle early or late. It runs this for the zero-means-64 read encoding, the largest read count, the largest write product, the special mode and the clamped low write counts.

Simultaneous requests on an idle port separate the read-first rule from any other priority. Same-direction requests placed inside a pending window show whether a grant restarts the countdown or leaves it running. A long mixed pattern of requests, with reset both at start-up and mid-run, is compared every cycle against a behavioural model that keeps only the last grant cycle and its limit.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;
endpackage

// File: rtl/tgc_gap_calc.sv
// Converts the bubble configuration into core-cycle spacing limits.
module tgc_gap_calc #(
    parameter int RD_BUB_W = 6,
    parameter int WR_BUB_W = 4,
    parameter int PER_W    = 4,
    parameter int RD_FIXED = 6,
    parameter int CNT_W    = 8
) (
    input  logic [RD_BUB_W-1:0] rd_bub,
    input  logic [WR_BUB_W-1:0] wr_bub,
    input  logic [PER_W-1:0]    period,
    input  logic                special,
    output logic [CNT_W-1:0]    rd_wr_lim,
    output logic [CNT_W-1:0]    wr_rd_lim
);
    localparam int RD_ZERO_VAL = 1 << RD_BUB_W;

    logic [CNT_W-1:0]    rd_base;
    logic [WR_BUB_W-1:0] wr_offs;
    logic [WR_BUB_W-1:0] wr_mult;

    always_comb begin
        rd_base   = (rd_bub == '0) ? CNT_W'(RD_ZERO_VAL) : CNT_W'(rd_bub);
        rd_wr_lim = rd_base + CNT_W'(RD_FIXED);

        wr_offs   = special ? WR_BUB_W'(2) : WR_BUB_W'(1);
        wr_mult   = (wr_bub > wr_offs) ? (wr_bub - wr_offs) : '0;
        wr_rd_lim = CNT_W'(wr_mult) * CNT_W'(period);
    end
endmodule

// File: rtl/tgc_arbiter.sv
// Decides which request may issue from the spacing state.
module tgc_arbiter (
    input  logic          rd_req,
    input  logic          wr_req,
    input  tgc_pkg::op_e  last_op,
    input  logic          gap_clear,
    output logic          rd_gnt,
    output logic          wr_gnt
);
    import tgc_pkg::*;

    always_comb begin
        rd_gnt = 1'b0;
        wr_gnt = 1'b0;
        if (gap_clear) begin
            rd_gnt = rd_req;
            wr_gnt = wr_req && !rd_req;
        end else if (last_op == OP_RD) begin
            rd_gnt = rd_req;
        end else if (last_op == OP_WR) begin
            wr_gnt = wr_req;
        end
    end
endmodule

// File: rtl/turnaround_gap_ctrl.sv
module turnaround_gap_ctrl #(
    parameter int RD_BUB_W = 6,
    parameter int WR_BUB_W = 4,
    parameter int PER_W    = 4,
    parameter int RD_FIXED = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic [RD_BUB_W-1:0] rd_bubbles,
    input  logic [WR_BUB_W-1:0] wr_bubbles,
    input  logic [PER_W-1:0]    frame_period,
    input  logic                single_rate_mode,
    output logic                rd_grant,
    output logic                wr_grant
);
    import tgc_pkg::*;

    localparam int RD_MAX  = (1 << RD_BUB_W) + RD_FIXED;
    localparam int WR_MAX  = ((1 << WR_BUB_W) - 2) * ((1 << PER_W) - 1);
    localparam int LIM_MAX = (RD_MAX > WR_MAX) ? RD_MAX : WR_MAX;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    typedef struct packed {
        op_e              last;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           state_d, state_q;
    logic [CNT_W-1:0] rd_wr_lim, wr_rd_lim;
    logic             gap_clear;

    tgc_gap_calc #(
        .RD_BUB_W (RD_BUB_W),
        .WR_BUB_W (WR_BUB_W),
        .PER_W    (PER_W),
        .RD_FIXED (RD_FIXED),
        .CNT_W    (CNT_W)
    ) i_calc (
        .rd_bub    (rd_bubbles),
        .wr_bub    (wr_bubbles),
        .period    (frame_period),
        .special   (single_rate_mode),
        .rd_wr_lim (rd_wr_lim),
        .wr_rd_lim (wr_rd_lim)
    );

    assign gap_clear = (state_q.cnt == '0);

    tgc_arbiter i_arb (
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .last_op   (state_q.last),
        .gap_clear (gap_clear),
        .rd_gnt    (rd_grant),
        .wr_gnt    (wr_grant)
    );

    // The grant cycle itself counts toward the gap, so a limit L loads L-1.
    function automatic logic [CNT_W-1:0] load_val(input logic [CNT_W-1:0] lim);
        return (lim == '0) ? '0 : lim - CNT_W'(1);
    endfunction

    always_comb begin
        state_d = state_q;
        if (state_q.cnt != '0) state_d.cnt = state_q.cnt - CNT_W'(1);
        if (rd_grant) begin
            state_d.last = OP_RD;
            state_d.cnt  = load_val(rd_wr_lim);
        end else if (wr_grant) begin
            state_d.last = OP_WR;
            state_d.cnt  = load_val(wr_rd_lim);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.last <= OP_NONE;
            state_q.cnt  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_grant && wr_grant));
    p_rd_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> rd_req);
    p_wr_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> wr_req);
    p_same_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.last == OP_RD && rd_req) |-> rd_grant);
    p_same_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.last == OP_WR && wr_req && !rd_req) |-> wr_grant);
    p_hold_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.last == OP_WR && state_q.cnt != '0) |-> !rd_grant);
    p_hold_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.last == OP_RD && state_q.cnt != '0) |-> !wr_grant);
    p_read_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && state_q.cnt == '0) |-> (rd_grant && !wr_grant));
    p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_grant && !wr_grant && state_q.cnt != '0)
        |=> (state_q.cnt == $past(state_q.cnt) - CNT_W'(1)));
endmodule

// File: tb/test_turnaround_gap_ctrl.sv
`timescale 1ns/1ps
module test_turnaround_gap_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0, wr_req = 1'b0;
    logic [5:0] rd_bubbles = '0;
    logic [3:0] wr_bubbles = 4'd4;
    logic [3:0] frame_period = 4'd3;
    logic       single_rate_mode = 1'b0;
    logic       rd_grant, wr_grant;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int m_last = 0;      // 0 none, 1 read, 2 write
    int m_gcyc = 0;
    int m_lim = 0;

    always #4 clk = ~clk;

    turnaround_gap_ctrl i_turnaround_gap_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .rd_bubbles(rd_bubbles), .wr_bubbles(wr_bubbles),
        .frame_period(frame_period), .single_rate_mode(single_rate_mode),
        .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    function automatic int rd_limit();
        return ((rd_bubbles == 0) ? 64 : int'(rd_bubbles)) + 6;
    endfunction

    function automatic int wr_limit();
        int off = single_rate_mode ? 2 : 1;
        if (int'(wr_bubbles) <= off) return 0;
        return (int'(wr_bubbles) - off) * int'(frame_period);
    endfunction

    task automatic step(input logic r, input logic w, input string tag);
        logic er, ew;
        logic ok;
        @(negedge clk);
        rd_req = r;
        wr_req = w;
        #1;
        ok = (m_last == 0) || ((cyc - m_gcyc) >= m_lim);
        if (ok) begin
            er = r;
            ew = w && !r;
        end else if (m_last == 1) begin
            er = r;
            ew = 1'b0;
        end else begin
            er = 1'b0;
            ew = w;
        end
        checks++;
        if (rd_grant !== er || wr_grant !== ew) begin
            errors++;
            $display("FAIL %s cycle %0d: rd_grant/wr_grant = %b%b expected %b%b",
                     tag, cyc, rd_grant, wr_grant, er, ew);
        end
        if (er) begin
            m_last = 1; m_gcyc = cyc; m_lim = rd_limit();
        end else if (ew) begin
            m_last = 2; m_gcyc = cyc; m_lim = wr_limit();
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd_req = 1'b0;
        wr_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_last = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        step(1'b0, 1'b0, "R1");               // idle after reset
        step(1'b1, 1'b1, "R7");               // read wins on idle port, R1 first grant
        repeat (75) step(1'b0, 1'b1, "R4");   // zero count means 64 + 6
        repeat (12) step(1'b1, 1'b0, "R3");   // (4-1)*3 = 9

        rd_bubbles = 6'd5;                    // 11-cycle read-to-write gap
        step(1'b1, 1'b0, "R2");
        repeat (3) step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, "R2");               // restarts the window
        repeat (14) step(1'b0, 1'b1, "R4");
        repeat (4) step(1'b1, 1'b1, "R2");    // write stream holds reads

        do_reset();
        single_rate_mode = 1'b1;              // (4-2)*3 = 6
        step(1'b0, 1'b1, "R5");
        repeat (8) step(1'b1, 1'b0, "R5");

        do_reset();
        single_rate_mode = 1'b0;
        wr_bubbles = 4'd1;
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        single_rate_mode = 1'b1;
        wr_bubbles = 4'd2;
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");

        do_reset();
        single_rate_mode = 1'b0;
        rd_bubbles = 6'd63;                   // 69 cycles
        step(1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        repeat (72) step(1'b0, 1'b1, "R4");

        do_reset();
        wr_bubbles = 4'd15;
        frame_period = 4'd8;                  // 14*8 = 112
        step(1'b0, 1'b1, "R1");
        repeat (115) step(1'b1, 1'b0, "R3");

        do_reset();
        rd_bubbles = 6'd2;
        wr_bubbles = 4'd3;
        frame_period = 4'd2;
        for (int i = 0; i < 300; i++) begin
            step(((i * 7) % 5) < 2, ((i * 3) % 7) < 4, "R8");
        end
        rd_req = 1'b0;
        wr_req = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule